// File: doc/BRIEF.md
# Ripple-Slice Integer ALU with Overflow-Safe Signed Compare

This block is a purely combinational integer arithmetic and logic unit whose datapath is a chain of identical one-bit cells. Each cell can optionally invert either operand. It then forms the bitwise AND, the bitwise OR and a full-adder sum, and passes its carry to the next cell up. The top cell is a separate variant. It also works out signed overflow and a corrected "less than" indication, which it sends back to the lowest cell.

A 4-bit control word selects the function. Bit 3 inverts operand `a`. Bit 2 inverts operand `b` and also supplies the carry into bit 0, so subtraction adds the two's complement of `b`. Bits 1:0 pick AND, OR, sum or compare. The signed compare does not rely on the raw sign of `a - b`. It uses that sign XOR signed overflow, so a subtraction that wraps still gives the correct answer. A zero flag and a signed-overflow flag go out next to the result.

The block has no clock, no reset and no handshake. Results follow the inputs combinationally. The stream convention of the surrounding design is applied by whatever registers the operands and the result.

Top module: `rslice_alu`

## Requirements
- R1: Control `0000` drives `result` to the bitwise AND of `a` and `b`.
- R2: Control `0001` drives `result` to the bitwise OR of `a` and `b`.
- R3: Control `0010` drives `result` to `a + b` modulo 2^WIDTH.
- R4: Control `0110` drives `result` to `a - b` modulo 2^WIDTH, formed as `a + ~b + 1`.
- R5: Control `0111` sets `result[0]` to 1 exactly when `a < b` as two's complement numbers, with all other bits 0. This holds even when `a - b` overflows.
- R6: Control `1100` drives `result` to the bitwise NOR of `a` and `b`.
- R7: For controls `0010`, `0110` and `0111`, `overflow` is 1 exactly when the true signed sum or difference cannot be represented in WIDTH bits.
- R8: `zero` is 1 exactly when every bit of `result` is 0.
- R9: The behaviour above holds for any WIDTH of 2 or more. At WIDTH 4, comparing `1001` (-7) with `0110` (6) wraps to a raw difference of `0011`, yet still gives `result` = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand |
| alu_ctl | input | 4 | {invert a, invert b / carry-in, function[1:0]} |
| result | output | WIDTH | Function output |
| overflow | output | 1 | Signed overflow of the adder chain |
| zero | output | 1 | High when result is all zeros |

## Verification
The block holds no state, so any wrong internal value shows up at the ports as soon as the inputs settle. No cycles pass before it is visible. A broken carry link corrupts sums and differences from that bit upward and usually flips `overflow` as well. A missing sign correction in the top cell shows only on compares whose difference overflows, so the vectors deliberately include the most negative and most positive operands. An exhaustive sweep at WIDTH 4 covers every carry path and every compare outcome in a narrow chain.

// File: rtl/rslice_alu_pkg.sv
package rslice_alu_pkg;
  typedef enum logic [1:0] {
    FN_AND  = 2'b00,
    FN_OR   = 2'b01,
    FN_SUM  = 2'b10,
    FN_LESS = 2'b11
  } slice_fn_e;

  localparam logic [3:0] CTL_AND = 4'b0000;
  localparam logic [3:0] CTL_OR  = 4'b0001;
  localparam logic [3:0] CTL_ADD = 4'b0010;
  localparam logic [3:0] CTL_SUB = 4'b0110;
  localparam logic [3:0] CTL_SLT = 4'b0111;
  localparam logic [3:0] CTL_NOR = 4'b1100;
endpackage

// File: rtl/rslice_bit.sv
module rslice_bit
  import rslice_alu_pkg::*;
(
  input  logic      a_i,
  input  logic      b_i,
  input  logic      inv_a_i,
  input  logic      inv_b_i,
  input  logic      cin_i,
  input  logic      less_i,
  input  slice_fn_e fn_i,
  output logic      res_o,
  output logic      cout_o
);
  logic aa, bb, sum;

  always_comb begin
    aa     = a_i ^ inv_a_i;
    bb     = b_i ^ inv_b_i;
    sum    = aa ^ bb ^ cin_i;
    cout_o = (aa & bb) | (cin_i & (aa ^ bb));
    unique case (fn_i)
      FN_AND:  res_o = aa & bb;
      FN_OR:   res_o = aa | bb;
      FN_SUM:  res_o = sum;
      default: res_o = less_i;
    endcase
  end
endmodule

// File: rtl/rslice_top_bit.sv
module rslice_top_bit
  import rslice_alu_pkg::*;
(
  input  logic      a_i,
  input  logic      b_i,
  input  logic      inv_a_i,
  input  logic      inv_b_i,
  input  logic      cin_i,
  input  logic      less_i,
  input  slice_fn_e fn_i,
  output logic      res_o,
  output logic      cout_o,
  output logic      ovf_o,
  output logic      set_o
);
  logic aa, bb, sum;

  always_comb begin
    aa     = a_i ^ inv_a_i;
    bb     = b_i ^ inv_b_i;
    sum    = aa ^ bb ^ cin_i;
    cout_o = (aa & bb) | (cin_i & (aa ^ bb));
    ovf_o  = cin_i ^ cout_o;
    set_o  = sum ^ ovf_o;
    unique case (fn_i)
      FN_AND:  res_o = aa & bb;
      FN_OR:   res_o = aa | bb;
      FN_SUM:  res_o = sum;
      default: res_o = less_i;
    endcase
  end

  // Overflow only when both effective operands share a sign that the sum lost.
  always_comb begin
    assert_ovf_sign_R7: assert (!ovf_o || ((aa == bb) && (sum != aa)))
      else $error("overflow flagged without a sign change");
  end
endmodule

// File: rtl/rslice_zero_det.sv
module rslice_zero_det #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] val_i,
  output logic             zero_o
);
  assign zero_o = ~|val_i;
endmodule

// File: rtl/rslice_alu.sv
module rslice_alu
  import rslice_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic [3:0]       alu_ctl,
  output logic [WIDTH-1:0] result,
  output logic             overflow,
  output logic             zero
);
  localparam int MSB = WIDTH - 1;

  logic      inv_a, inv_b;
  slice_fn_e fn;
  logic      lt_set;

  assign inv_a = alu_ctl[3];
  assign inv_b = alu_ctl[2];
  assign fn    = slice_fn_e'(alu_ctl[1:0]);

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic ci, co, less_in;
    if (i == 0) begin : g_lo
      assign ci      = inv_b;
      assign less_in = lt_set;
    end else begin : g_hi
      assign ci      = g_bit[i-1].co;
      assign less_in = 1'b0;
    end

    if (i == MSB) begin : g_top
      rslice_top_bit u_cell (
        .a_i     (a[i]),
        .b_i     (b[i]),
        .inv_a_i (inv_a),
        .inv_b_i (inv_b),
        .cin_i   (ci),
        .less_i  (less_in),
        .fn_i    (fn),
        .res_o   (result[i]),
        .cout_o  (co),
        .ovf_o   (overflow),
        .set_o   (lt_set)
      );
    end else begin : g_mid
      rslice_bit u_cell (
        .a_i     (a[i]),
        .b_i     (b[i]),
        .inv_a_i (inv_a),
        .inv_b_i (inv_b),
        .cin_i   (ci),
        .less_i  (less_in),
        .fn_i    (fn),
        .res_o   (result[i]),
        .cout_o  (co)
      );
    end
  end

  rslice_zero_det #(.WIDTH(WIDTH)) u_zero (
    .val_i  (result),
    .zero_o (zero)
  );

  // Output-level checks against operand arithmetic.
  always_comb begin
    if (alu_ctl == CTL_AND)
      assert_and_R1: assert (result == (a & b)) else $error("AND mismatch");
    if (alu_ctl == CTL_ADD)
      assert_add_R3: assert (result == (a + b)) else $error("ADD mismatch");
    if (alu_ctl == CTL_SUB)
      assert_sub_R4: assert (result == (a - b)) else $error("SUB mismatch");
    if (alu_ctl == CTL_SLT) begin
      assert_slt_bit_R5: assert (result[0] == ($signed(a) < $signed(b)))
        else $error("SLT compare wrong");
      assert_slt_upper_R5: assert ((result >> 1) == '0)
        else $error("SLT upper bits set");
    end
    if (alu_ctl == CTL_NOR)
      assert_nor_R6: assert (result == ~(a | b)) else $error("NOR mismatch");
  end
endmodule

// File: tb/rslice_alu_tb.sv
module rslice_alu_tb;
  import rslice_alu_pkg::*;

  typedef struct packed {
    logic [3:0]  ctl;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] res;
    logic        ovf;
    logic        ovf_chk;
    logic        zero;
  } vec_t;

  localparam int NVEC = 18;
  localparam vec_t VECS [NVEC] = '{
    '{4'b0000, 32'hF0F0F0F0, 32'hFF00FF00, 32'hF000F000, 1'b0, 1'b0, 1'b0}, // R1
    '{4'b0001, 32'h0F0F0000, 32'h00F0000F, 32'h0FFF000F, 1'b0, 1'b0, 1'b0}, // R2
    '{4'b0000, 32'h12345678, 32'hEDCBA987, 32'h00000000, 1'b0, 1'b0, 1'b1}, // R1 R8
    '{4'b0010, 32'h00000005, 32'h00000007, 32'h0000000C, 1'b0, 1'b1, 1'b0}, // R3
    '{4'b0010, 32'h7FFFFFFF, 32'h00000001, 32'h80000000, 1'b1, 1'b1, 1'b0}, // R3 R7
    '{4'b0010, 32'h80000000, 32'h80000000, 32'h00000000, 1'b1, 1'b1, 1'b1}, // R3 R7
    '{4'b0010, 32'hFFFFFFFF, 32'h00000001, 32'h00000000, 1'b0, 1'b1, 1'b1}, // R3 R8
    '{4'b0110, 32'h0000000A, 32'h00000003, 32'h00000007, 1'b0, 1'b1, 1'b0}, // R4
    '{4'b0110, 32'h80000000, 32'h00000001, 32'h7FFFFFFF, 1'b1, 1'b1, 1'b0}, // R4 R7
    '{4'b0110, 32'h7FFFFFFF, 32'hFFFFFFFF, 32'h80000000, 1'b1, 1'b1, 1'b0}, // R4 R7
    '{4'b0110, 32'h00000003, 32'h00000003, 32'h00000000, 1'b0, 1'b1, 1'b1}, // R4 R8
    '{4'b0111, 32'hFFFFFFF9, 32'h00000006, 32'h00000001, 1'b0, 1'b1, 1'b0}, // R5
    '{4'b0111, 32'h80000000, 32'h00000001, 32'h00000001, 1'b1, 1'b1, 1'b0}, // R5 overflowing
    '{4'b0111, 32'h7FFFFFFF, 32'hFFFFFFFF, 32'h00000000, 1'b1, 1'b1, 1'b1}, // R5 overflowing
    '{4'b0111, 32'h00000006, 32'hFFFFFFF9, 32'h00000000, 1'b0, 1'b1, 1'b1}, // R5
    '{4'b0111, 32'h00000005, 32'h00000005, 32'h00000000, 1'b0, 1'b1, 1'b1}, // R5 equal
    '{4'b0111, 32'hFFFFFFFE, 32'hFFFFFFFF, 32'h00000001, 1'b0, 1'b1, 1'b0}, // R5
    '{4'b1100, 32'h0F0F0F0F, 32'h00FF00FF, 32'hF000F000, 1'b0, 1'b0, 1'b0}  // R6
  };

  logic clk = 1'b0;
  always #5ns clk = ~clk;

  logic [31:0] a, b, result;
  logic [3:0]  ctl;
  logic        overflow, zero;
  logic [3:0]  a4, b4, result4;
  logic [3:0]  ctl4;
  logic        overflow4, zero4;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  rslice_alu #(.WIDTH(32)) u_dut (
    .a(a), .b(b), .alu_ctl(ctl), .result(result), .overflow(overflow), .zero(zero)
  );

  rslice_alu #(.WIDTH(4)) u_dut_w4 (
    .a(a4), .b(b4), .alu_ctl(ctl4), .result(result4), .overflow(overflow4), .zero(zero4)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply32(input logic [3:0] c, input logic [31:0] x, input logic [31:0] y);
    @(posedge clk);
    ctl = c; a = x; b = y;
    @(negedge clk);
  endtask

  initial begin
    a = '0; b = '0; ctl = CTL_AND;
    a4 = '0; b4 = '0; ctl4 = CTL_AND;
    @(negedge clk);
    // Idle state: zero operands under AND give an all-zero result (R1, R8)
    check("R1 idle result", result, 32'h0);
    check("R8 idle zero", {31'b0, zero}, 32'h1);

    for (int i = 0; i < NVEC; i++) begin
      apply32(VECS[i].ctl, VECS[i].a, VECS[i].b);
      check("R1-R6 vector result", result, VECS[i].res);
      check("R8 vector zero", {31'b0, zero}, {31'b0, VECS[i].zero});
      if (VECS[i].ovf_chk)
        check("R7 vector overflow", {31'b0, overflow}, {31'b0, VECS[i].ovf});
    end

    // R9: the wrapping compare at four bits
    @(posedge clk);
    ctl4 = CTL_SLT; a4 = 4'b1001; b4 = 4'b0110;
    @(negedge clk);
    check("R9 slt -7<6 at width 4", {28'b0, result4}, 32'h1);
    check("R9 overflow on wrapped diff", {31'b0, overflow4}, 32'h1);

    // R9 exhaustive at WIDTH 4 against signed arithmetic
    for (int op = 0; op < 3; op++) begin
      for (int x = 0; x < 16; x++) begin
        for (int y = 0; y < 16; y++) begin
          int sx, sy, tr;
          logic [3:0] er;
          logic eo;
          sx = (x > 7) ? x - 16 : x;
          sy = (y > 7) ? y - 16 : y;
          @(posedge clk);
          a4 = 4'(x); b4 = 4'(y);
          ctl4 = (op == 0) ? CTL_ADD : (op == 1) ? CTL_SUB : CTL_SLT;
          tr = (op == 0) ? sx + sy : sx - sy;
          eo = (tr > 7) || (tr < -8);
          er = (op == 2) ? ((sx < sy) ? 4'd1 : 4'd0) : 4'(tr);
          @(negedge clk);
          check("R9 sweep result (R3 R4 R5)", {28'b0, result4}, {28'b0, er});
          check("R9 sweep overflow R7", {31'b0, overflow4}, {31'b0, eo});
          check("R9 sweep zero R8", {31'b0, zero4}, {31'b0, (er == 4'd0)});
        end
      end
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule